// File: doc/BRIEF.md
# Clock-Stepped Boot Feeder

This block starts a 6502-class CPU that has no ROM. At power-up it owns the CPU clock: the CPU runs on single pulses that the block generates itself, and the block supplies every byte the CPU reads while it boots. It holds the CPU in reset for a set number of stepped cycles. It then lets the CPU run through its seven-cycle reset sequence and answers the two vector reads. After that it feeds a fixed instruction stream. For each byte of a boot image that is built into the block, the stream contains a load-immediate and then a store-absolute to consecutive RAM locations. The stream ends with an absolute jump to the first image byte.

The block does not decode addresses. It knows what the CPU reads by counting stepped cycles, and it looks at R/W only so that it leaves the data bus alone whenever the CPU writes. Once the jump has been fed, it stops stepping. It moves the clock switch over to the free-running oscillator at an instant when both clocks are low, raises a done flag, and after that neither drives the bus nor pulses the stepped clock again.

Top module: `step_boot`

## Requirements
- R1: While rst_ni is low: done_o=0, clk_sel_o=0 (stepped source), cpu_rst_no=0, data_oe_o=0 and step_clk_o=0.
- R2: After reset, cpu_rst_no stays low for exactly HOLD_CYC falling edges of step_clk_o, and then goes high.
- R3: Once the CPU is out of reset, seven read cycles are answered. The 6th read gets VEC_ADDR[7:0] and the 7th gets VEC_ADDR[15:0] high byte. The first five get filler byte 8'hEA.
- R4: For image byte i, the CPU next reads opcode 8'hA9, then the byte, then opcode 8'h8D, then the low byte and then the high byte of LOAD_ADDR+i. This is repeated for every i from 0 to IMG_LEN-1, and every such read cycle is driven.
- R5: After boot, RAM location LOAD_ADDR+i holds image byte IMG_DATA[8*i+7:8*i] for every i.
- R6: data_oe_o is low in every cycle in which rw_i is low, including the fourth cycle of each store.
- R7: After the last store, the CPU reads 8'h4C, then LOAD_ADDR low byte and then high byte. Its first fetch on the oscillator clock is from LOAD_ADDR.
- R8: clk_sel_o changes only from 0 to 1, and only at a clk_i edge at which both step_clk_o and osc_i were sampled low.
- R9: done_o rises only after clk_sel_o is 1 and then stays high. While done_o is high, data_oe_o and step_clk_o stay low.
- R10: While stepping, every high phase and every low phase of step_clk_o lasts exactly HALF_CYC clk_i cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the stepped CPU clock is derived from it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | Free-running oscillator clock, handed to the CPU after boot |
| rw_i | input | 1 | CPU R/W, high = read |
| cpu_clk_o | output | 1 | Clock to the CPU, from the switch |
| clk_sel_o | output | 1 | Switch position, 0 = stepped, 1 = oscillator |
| step_clk_o | output | 1 | Stepped clock generated by the block |
| cpu_rst_no | output | 1 | CPU reset, active low |
| data_o | output | 8 | Byte offered to the CPU data bus |
| data_oe_o | output | 1 | Drive enable for data_o |
| done_o | output | 1 | Boot complete, bus released |

## Verification
Two things can fall in the same clk_i cycle. One is the switch request, raised in the low phase right after the jump's high byte has been read. The other is the oscillator's low phase, which gives the switch its permission. With one oscillator phasing, the oscillator is already low when the request rises and the switch happens at once. With another phasing, the request has to wait out a high phase. The bench runs the boot with two oscillator half-periods to reach both cases. In each case it checks that, at the edge where the select moved, both clocks had been sampled low, and that the CPU model's first oscillator-clocked fetch still comes from the load address.

// File: rtl/step_boot_pkg.sv
package step_boot_pkg;

  localparam logic [7:0] OP_LDA_IMM = 8'hA9;
  localparam logic [7:0] OP_STA_ABS = 8'h8D;
  localparam logic [7:0] OP_JMP_ABS = 8'h4C;
  localparam logic [7:0] OP_FILL    = 8'hEA;

  localparam int unsigned RSEQ_CYC  = 7;
  localparam int unsigned RSEQ_VLO  = 5;
  localparam int unsigned RSEQ_VHI  = 6;

  typedef enum logic [3:0] {
    ST_HOLD, ST_RSEQ,
    ST_LDA_OP, ST_LDA_IMM,
    ST_STA_OP, ST_STA_LO, ST_STA_HI, ST_STA_WR,
    ST_JMP_OP, ST_JMP_LO, ST_JMP_HI,
    ST_SWAP, ST_DONE
  } seq_st_e;

  // states in which the CPU performs a read the block must answer
  function automatic logic st_reads(seq_st_e s);
    case (s)
      ST_RSEQ, ST_LDA_OP, ST_LDA_IMM, ST_STA_OP, ST_STA_LO, ST_STA_HI,
      ST_JMP_OP, ST_JMP_LO, ST_JMP_HI: st_reads = 1'b1;
      default:                          st_reads = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/step_boot_stepgen.sv
module step_boot_stepgen #(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned CW       = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic step_o,
  output logic fall_o
);

  logic [CW-1:0] cnt_q;
  logic          step_q;
  logic          fall_q;

  // halts only in the low phase: a started high phase always completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (cnt_q == CW'(HALF_CYC - 1)) begin
        cnt_q <= '0;
        if (step_q) begin
          step_q <= 1'b0;
          fall_q <= 1'b1;
        end else if (run_i) begin
          step_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign step_o = step_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/step_boot_image.sv
module step_boot_image #(
  parameter int unsigned         IMG_LEN  = 6,
  parameter int unsigned         IDX_W    = 3,
  parameter logic [IMG_LEN*8-1:0] IMG_DATA = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);

  logic [7:0] tbl [IMG_LEN];

  for (genvar g = 0; g < IMG_LEN; g++) begin : g_tbl
    assign tbl[g] = IMG_DATA[g*8 +: 8];
  end

  assign byte_o = tbl[idx_i];

endmodule

// File: rtl/step_boot_clksw.sv
module step_boot_clksw (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic step_i,
  input  logic osc_i,
  output logic sel_o,
  output logic clk_o
);

  logic sel_q;

  // one-way switch, moved only while both sources are low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              sel_q <= 1'b0;
    else if (req_i && !step_i && !osc_i)      sel_q <= 1'b1;
  end

  assign sel_o = sel_q;
  assign clk_o = sel_q ? osc_i : step_i;

endmodule

// File: rtl/step_boot_seq.sv
module step_boot_seq
  import step_boot_pkg::*;
#(
  parameter int unsigned IMG_LEN   = 6,
  parameter int unsigned IDX_W     = 3,
  parameter int unsigned HOLD_CYC  = 4,
  parameter logic [15:0] LOAD_ADDR = 16'h0300,
  parameter logic [15:0] VEC_ADDR  = 16'hF000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic             rw_i,
  input  logic             sel_i,
  input  logic [7:0]       img_byte_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             run_o,
  output logic             swap_req_o,
  output logic             cpu_rst_no,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             done_o
);

  localparam int unsigned CNT_MAX = (HOLD_CYC > RSEQ_CYC) ? HOLD_CYC : RSEQ_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [15:0]      tgt;
  logic             last_byte;

  assign tgt       = LOAD_ADDR + 16'(idx_q);
  assign last_byte = (idx_q == IDX_W'(IMG_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_HOLD;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (st_q == ST_SWAP) begin
      if (sel_i) st_q <= ST_DONE;
    end else if (fall_i) begin
      case (st_q)
        ST_HOLD: begin
          if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_RSEQ;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RSEQ: begin
          if (cnt_q == CNT_W'(RSEQ_CYC - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_LDA_OP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_LDA_OP:  st_q <= ST_LDA_IMM;
        ST_LDA_IMM: st_q <= ST_STA_OP;
        ST_STA_OP:  st_q <= ST_STA_LO;
        ST_STA_LO:  st_q <= ST_STA_HI;
        ST_STA_HI:  st_q <= ST_STA_WR;
        ST_STA_WR: begin
          if (last_byte) begin
            st_q <= ST_JMP_OP;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_LDA_OP;
          end
        end
        ST_JMP_OP:  st_q <= ST_JMP_LO;
        ST_JMP_LO:  st_q <= ST_JMP_HI;
        ST_JMP_HI:  st_q <= ST_SWAP;
        default:    st_q <= st_q;
      endcase
    end
  end

  always_comb begin
    data_o = OP_FILL;
    case (st_q)
      ST_RSEQ: begin
        if (cnt_q == CNT_W'(RSEQ_VLO))      data_o = VEC_ADDR[7:0];
        else if (cnt_q == CNT_W'(RSEQ_VHI)) data_o = VEC_ADDR[15:8];
      end
      ST_LDA_OP:  data_o = OP_LDA_IMM;
      ST_LDA_IMM: data_o = img_byte_i;
      ST_STA_OP:  data_o = OP_STA_ABS;
      ST_STA_LO:  data_o = tgt[7:0];
      ST_STA_HI:  data_o = tgt[15:8];
      ST_JMP_OP:  data_o = OP_JMP_ABS;
      ST_JMP_LO:  data_o = LOAD_ADDR[7:0];
      ST_JMP_HI:  data_o = LOAD_ADDR[15:8];
      default:    data_o = OP_FILL;
    endcase
  end

  assign data_oe_o  = st_reads(st_q) && rw_i;
  assign run_o      = (st_q != ST_SWAP) && (st_q != ST_DONE);
  assign swap_req_o = (st_q == ST_SWAP);
  assign cpu_rst_no = (st_q != ST_HOLD);
  assign done_o     = (st_q == ST_DONE);
  assign idx_o      = idx_q;

endmodule

// File: rtl/step_boot.sv
module step_boot #(
  parameter int unsigned          HALF_CYC  = 2,
  parameter int unsigned          HOLD_CYC  = 4,
  parameter int unsigned          IMG_LEN   = 6,
  parameter logic [IMG_LEN*8-1:0] IMG_DATA  = 48'h5A_C3_01_FF_80_3E,
  parameter logic [15:0]          LOAD_ADDR = 16'h0300,
  parameter logic [15:0]          VEC_ADDR  = 16'hF000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_i,
  input  logic       rw_i,
  output logic       cpu_clk_o,
  output logic       clk_sel_o,
  output logic       step_clk_o,
  output logic       cpu_rst_no,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       done_o
);

  localparam int unsigned IDX_W = (IMG_LEN > 1) ? $clog2(IMG_LEN) : 1;
  localparam int unsigned PH_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic             run;
  logic             fall;
  logic             swap_req;
  logic [IDX_W-1:0] idx;
  logic [7:0]       img_byte;

  step_boot_stepgen #(.HALF_CYC(HALF_CYC), .CW(PH_W)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .step_o (step_clk_o),
    .fall_o (fall)
  );

  step_boot_image #(.IMG_LEN(IMG_LEN), .IDX_W(IDX_W), .IMG_DATA(IMG_DATA)) u_img (
    .idx_i  (idx),
    .byte_o (img_byte)
  );

  step_boot_seq #(
    .IMG_LEN(IMG_LEN), .IDX_W(IDX_W), .HOLD_CYC(HOLD_CYC),
    .LOAD_ADDR(LOAD_ADDR), .VEC_ADDR(VEC_ADDR)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .rw_i       (rw_i),
    .sel_i      (clk_sel_o),
    .img_byte_i (img_byte),
    .idx_o      (idx),
    .run_o      (run),
    .swap_req_o (swap_req),
    .cpu_rst_no (cpu_rst_no),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .done_o     (done_o)
  );

  step_boot_clksw u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (swap_req),
    .step_i (step_clk_o),
    .osc_i  (osc_i),
    .sel_o  (clk_sel_o),
    .clk_o  (cpu_clk_o)
  );

endmodule

// File: rtl/step_boot_chk.sv
module step_boot_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_i,
  input logic rw_i,
  input logic clk_sel_o,
  input logic step_clk_o,
  input logic cpu_rst_no,
  input logic data_oe_o,
  input logic done_o
);

  assert_no_drive_on_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_i |-> !data_oe_o);

  assert_switch_when_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o != $past(clk_sel_o)) |-> ($past(!step_clk_o) && $past(!osc_i) && clk_sel_o));

  assert_done_after_switch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> clk_sel_o);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_quiet_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!data_oe_o && !step_clk_o));

  assert_not_done_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rst_no |-> (!done_o && !data_oe_o && !clk_sel_o));

endmodule

bind step_boot step_boot_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_i      (osc_i),
  .rw_i       (rw_i),
  .clk_sel_o  (clk_sel_o),
  .step_clk_o (step_clk_o),
  .cpu_rst_no (cpu_rst_no),
  .data_oe_o  (data_oe_o),
  .done_o     (done_o)
);

// File: tb/sim_step_boot.sv
module sim_step_boot;

  localparam int          CLK_PERIOD = 10;
  localparam int          HALF       = 2;
  localparam int          HOLD       = 4;
  localparam int          NIMG       = 6;
  localparam logic [47:0] IMG        = 48'h5A_C3_01_FF_80_3E;
  localparam logic [15:0] LOAD       = 16'h0300;
  localparam logic [15:0] VEC        = 16'hF000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic       rw = 1'b1;
  logic       cpu_clk, sel, step, cpu_rst_n, oe, done;
  logic [7:0] dat;

  int n_chk = 0, n_bad = 0;
  int osc_half = 3, osc_cnt = 0;

  step_boot #(
    .HALF_CYC(HALF), .HOLD_CYC(HOLD), .IMG_LEN(NIMG), .IMG_DATA(IMG),
    .LOAD_ADDR(LOAD), .VEC_ADDR(VEC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .rw_i(rw),
    .cpu_clk_o(cpu_clk), .clk_sel_o(sel), .step_clk_o(step),
    .cpu_rst_no(cpu_rst_n), .data_o(dat), .data_oe_o(oe), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (osc_cnt >= osc_half - 1) begin osc_cnt <= 0; osc <= ~osc; end
    else osc_cnt <= osc_cnt + 1;
  end

  // CPU bus model and monitors
  logic [7:0]  ram [64];
  logic        p_cpu = 1'b0, p_sel = 1'b0, p_step = 1'b0, p_osc = 1'b0;
  int          hold_falls, undriven, bad_drive, post_bad, sw_seen, sw_bad;
  int          n_lda, n_sta, n_jmp, bad_width, phases, run_len;
  logic [15:0] vec_seen, first_fetch, pc, opnd;
  logic [7:0]  a_reg, op, lo, fe_seq_bad;
  int          rk, t;
  bit          in_rs, fetched_osc;

  task automatic clear_stats();
    hold_falls = 0; undriven = 0; bad_drive = 0; post_bad = 0; sw_seen = 0; sw_bad = 0;
    n_lda = 0; n_sta = 0; n_jmp = 0; bad_width = 0; phases = 0; run_len = 0;
    vec_seen = 16'h0; first_fetch = 16'hDEAD; pc = 16'h0; opnd = 16'h0;
    a_reg = 8'h0; op = 8'h0; lo = 8'h0; fe_seq_bad = 8'h0;
    rk = 0; t = 0; in_rs = 1'b1; fetched_osc = 1'b0; rw = 1'b1;
    for (int i = 0; i < 64; i++) ram[i] = 8'h00;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (sel !== p_sel) begin
        sw_seen++;
        if (p_step || p_osc || p_sel) sw_bad++;
      end
      if (!done) begin
        if (step === p_step) run_len++;
        else begin
          if (run_len != HALF) bad_width++;
          phases++;
          run_len = 1;
        end
      end
      if (!rw && oe) bad_drive++;
      if (done && (oe || step)) post_bad++;
      if (p_cpu && !cpu_clk) begin
        if (!cpu_rst_n) begin
          if (!sel) hold_falls++;
          in_rs = 1'b1; rk = 0; t = 0; rw = 1'b1;
        end else if (sel) begin
          if (!fetched_osc) begin first_fetch = pc; fetched_osc = 1'b1; end
        end else begin
          if (rw && !oe) undriven++;
          if (in_rs) begin
            if (rk < 5 && dat !== 8'hEA) fe_seq_bad++;
            if (rk == 5) lo = dat;
            if (rk == 6) begin vec_seen = {dat, lo}; pc = {dat, lo}; in_rs = 1'b0; t = 0; end
            rk++;
          end else if (t == 0) begin
            op = dat; pc++; t = 1;
          end else begin
            case (op)
              8'hA9: begin a_reg = dat; pc++; t = 0; n_lda++; end
              8'h8D: begin
                if (t == 1) begin lo = dat; pc++; t = 2; end
                else if (t == 2) begin opnd = {dat, lo}; pc++; t = 3; end
                else begin
                  if (opnd >= LOAD && opnd < LOAD + 16'd64) ram[opnd - LOAD] = a_reg;
                  n_sta++; t = 0;
                end
              end
              8'h4C: begin
                if (t == 1) begin lo = dat; t = 2; end
                else begin pc = {dat, lo}; t = 0; n_jmp++; end
              end
              default: begin t = 0; undriven++; end
            endcase
          end
          rw = !(op == 8'h8D && t == 3);
        end
      end
    end
    p_cpu = cpu_clk; p_sel = sel; p_step = step; p_osc = osc;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && sel == 1'b0, "R1 done/sel in reset", {done, sel}, 0);
    check(cpu_rst_n == 1'b0, "R1 cpu reset held", cpu_rst_n, 0);
    check(oe == 1'b0 && step == 1'b0, "R1 bus/step idle", {oe, step}, 0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    repeat (6 * osc_half + 4) @(negedge clk);
  endtask

  task automatic check_boot(input string tag);
    $display("-- checking %s", tag);
    check(hold_falls == HOLD, "R2 reset hold length", hold_falls, HOLD);
    check(vec_seen == VEC && fe_seq_bad == 0, "R3 vector bytes", vec_seen, VEC);
    check(n_lda == NIMG && n_sta == NIMG, "R4 load/store count", n_lda * 100 + n_sta, NIMG * 101);
    check(undriven == 0, "R4 every read driven", undriven, 0);
    for (int i = 0; i < NIMG; i++)
      check(ram[i] == IMG[i*8 +: 8], "R5 image byte", ram[i], IMG[i*8 +: 8]);
    check(bad_drive == 0, "R6 no drive in write cycle", bad_drive, 0);
    check(n_jmp == 1, "R7 jump fed once", n_jmp, 1);
    check(first_fetch == LOAD, "R7 first oscillator fetch", first_fetch, LOAD);
    check(sw_seen == 1 && sw_bad == 0, "R8 clean switch", sw_seen * 10 + sw_bad, 10);
    check(sel == 1'b1, "R8 oscillator selected", sel, 1);
    check(done == 1'b1 && post_bad == 0, "R9 done and quiet", {done, 8'(post_bad)}, 256);
    check(bad_width == 0 && phases > 20, "R10 step phase width", bad_width, 0);
  endtask

  task automatic t_boot(input int oh, input string tag);
    t_reset_state();
    osc_half = oh;
    clear_stats();
    @(negedge clk); rst_n = 1'b1;
    wait_done();
    check_boot(tag);
  endtask

  task automatic t_midreset();
    t_reset_state();
    osc_half = 4;
    clear_stats();
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4000 && n_sta < 2; i++) @(negedge clk);
    t_reset_state();
    clear_stats();
    @(negedge clk); rst_n = 1'b1;
    wait_done();
    check_boot("restart after mid-boot reset");
  endtask

  initial begin
    clear_stats();
    t_boot(3, "oscillator half 3");
    t_boot(5, "oscillator half 5");
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule